// File: doc/BRIEF.md
# Programmable Baud Clock Generator

This block derives a data clock for a serial channel from a system clock. Software loads a 16-bit divide value through a small byte-wide write port. The value is split across two byte registers, one for the high half and one for the low half. A third byte register selects where the count ticks come from and whether the divider runs. It also selects the output shape. Ticks can come from the system clock, from one of five prescaled versions of it, or from rising edges of an external clock pin. The output is either a 50% square wave or a train of pulses, each one system-clock cycle wide.

No derived clocks exist inside the block. The prescaler and the external-edge detector each produce a single-cycle enable in the system clock domain. A two-state machine controls the divider. `ST_HOLD` is the stopped state: the output is held low and the counter is cleared. `ST_RUN` counts ticks up to the latched period. The transition `HOLD->RUN` is taken when the run bit is 1, and it loads the preset. The transition `RUN->HOLD` is taken as soon as the run bit is 0. A new preset is picked up only at the terminal count, so a period that has already started is never cut short.

Top module: `baud_clkgen`

## Requirements
- R1: Register writes use `bus_wr` with `bus_addr`: address 0 loads preset bits 15:8 and address 1 loads preset bits 7:0, each write leaving the other byte intact. Address 2 loads the control byte: bits 2:0 are the source select, bit 3 is run, and bit 4 is the mode (0 = square, 1 = pulse).
- R2: The preset bytes are write-only, so `bus_rdata` reads 0x00 at addresses 0 and 1. At address 2 it returns the control byte, with bits 7:5 reading 0.
- R3: In square mode with preset n and tick interval D, `baud_out` has a period of 2·max(n,1)·D system-clock cycles and stays high for max(n,1)·D cycles.
- R4: In pulse mode the period is max(n,1)·D cycles. Whenever that period is longer than one cycle, each high pulse lasts exactly one cycle.
- R5: The source select sets D as follows: 000→1, 001→2, 010→16, 011→32, 100→64, 101→128.
- R6: While run is 0 the divider stays in `ST_HOLD`. `baud_out` goes low in the cycle after run reads 0 and stays low, and neither ticks nor count advances occur.
- R7: A preset of 0x0000 is accepted and behaves exactly like a preset of 1.
- R8: Select value 111 produces no ticks. The count and `baud_out` stay frozen while it is selected.
- R9: A preset written during a period takes effect only at the next terminal count or at the next release from hold. The interval already in progress completes with the old value.
- R10: Select 110 uses `ext_clk` through a two-flop synchronizer and gives one tick per rising edge, so D equals the external period in system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the byte registers |
| bus_addr | input | 2 | Register address for writes and reads |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (control byte only; presets read 0) |
| ext_clk | input | 1 | External tick source, asynchronous |
| baud_out | output | 1 | Divided data clock |

## Verification
A wrong count or a latched period that goes stale shows up directly in the spacing of `baud_out` edges, and it does so within one output period. The bench measures full periods and high widths against values it computes from n, D and the mode. A wrong prescaler phase or a wrong synchronizer shows up as a D that is off by a factor, and this is caught within one period. A state machine stuck in run shows up at once, because `baud_out` stays high after the run bit is cleared. Reloading the preset before the terminal count shows up as a shortened first half-period after a write in the middle of a period.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic {ST_HOLD, ST_RUN} div_state_e;

    localparam logic [2:0] SRC_EXT = 3'b110;
    localparam logic [2:0] SRC_OFF = 3'b111;

    // log2 of the prescale ratio for each internal source code
    function automatic int unsigned src_shift(input logic [2:0] s);
        case (s)
            3'b000:  return 0;
            3'b001:  return 1;
            3'b010:  return 4;
            3'b011:  return 5;
            3'b100:  return 6;
            default: return 7;
        endcase
    endfunction
endpackage

// File: rtl/bcg_regs.sv
module bcg_regs #(
    parameter int DATA_W   = 8,
    parameter int PRESET_W = 16,
    parameter int ADDR_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [PRESET_W-1:0] preset,
    output logic [2:0]          src_sel,
    output logic                run,
    output logic                pulse_mode
);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);
    localparam int HI_W = PRESET_W - DATA_W;

    logic [HI_W-1:0]   hi_q;
    logic [DATA_W-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q       <= '0;
            lo_q       <= '0;
            src_sel    <= 3'b000;
            run        <= 1'b0;
            pulse_mode <= 1'b0;
        end else if (wr) begin
            unique case (addr)
                A_HI:    hi_q <= wdata[HI_W-1:0];
                A_LO:    lo_q <= wdata;
                A_CTRL: begin
                    src_sel    <= wdata[2:0];
                    run        <= wdata[3];
                    pulse_mode <= wdata[4];
                end
                default: ;
            endcase
        end
    end

    assign preset = {hi_q, lo_q};

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL)
            rdata = DATA_W'({pulse_mode, run, src_sel});
    end
endmodule

// File: rtl/bcg_tick_src.sv
module bcg_tick_src
    import bcg_pkg::*;
#(
    parameter int PRE_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    input  logic       ext_in,
    output logic       tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] mask;
    logic [2:0]       ext_sync;
    logic             ext_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pre_cnt <= '0;
        else if (!run) pre_cnt <= '0;
        else           pre_cnt <= pre_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_sync <= '0;
        else        ext_sync <= {ext_sync[1:0], ext_in};
    end

    assign ext_edge = ext_sync[1] & ~ext_sync[2];
    assign mask     = PRE_W'((32'd1 << src_shift(sel)) - 32'd1);

    always_comb begin
        tick = 1'b0;
        if (run) begin
            unique case (sel)
                SRC_EXT: tick = ext_edge;
                SRC_OFF: tick = 1'b0;
                default: tick = ((pre_cnt & mask) == mask);
            endcase
        end
    end
endmodule

// File: rtl/bcg_divider.sv
module bcg_divider
    import bcg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             pulse_mode,
    input  logic [CNT_W-1:0] preset,
    output logic             div_out,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] period,
    output logic             running
);
    div_state_e       state, state_nxt;
    logic [CNT_W-1:0] preset_eff;
    logic             terminal;
    logic             sq_q, pls_q;

    assign preset_eff = (preset == '0) ? CNT_W'(1) : preset;
    assign running    = (state == ST_RUN);
    assign terminal   = running && run && tick && (cnt == period - 1'b1);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOLD: if (run)  state_nxt = ST_RUN;
            ST_RUN:  if (!run) state_nxt = ST_HOLD;
            default: state_nxt = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            period <= CNT_W'(1);
        end else if (!running || !run) begin
            cnt    <= '0;
            period <= preset_eff;
        end else if (tick) begin
            if (terminal) begin
                cnt    <= '0;
                period <= preset_eff;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q  <= 1'b0;
            pls_q <= 1'b0;
        end else if (!running || !run) begin
            sq_q  <= 1'b0;
            pls_q <= 1'b0;
        end else begin
            sq_q  <= sq_q ^ terminal;
            pls_q <= terminal;
        end
    end

    assign div_out = pulse_mode ? pls_q : sq_q;
endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen #(
    parameter int DATA_W   = 8,
    parameter int PRESET_W = 16,
    parameter int ADDR_W   = 2,
    parameter int PRE_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_clk,
    output logic              baud_out
);
    logic [PRESET_W-1:0] preset;
    logic [2:0]          src_sel;
    logic                run_q;
    logic                pulse_mode;
    logic                src_tick;
    logic [PRESET_W-1:0] div_cnt;
    logic [PRESET_W-1:0] div_period;
    logic                div_running;

    bcg_regs #(.DATA_W(DATA_W), .PRESET_W(PRESET_W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .rdata(bus_rdata), .preset(preset), .src_sel(src_sel), .run(run_q),
        .pulse_mode(pulse_mode)
    );

    bcg_tick_src #(.PRE_W(PRE_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .run(run_q), .sel(src_sel), .ext_in(ext_clk),
        .tick(src_tick)
    );

    bcg_divider #(.CNT_W(PRESET_W)) div_i (
        .clk(clk), .rst_n(rst_n), .run(run_q), .tick(src_tick), .pulse_mode(pulse_mode),
        .preset(preset), .div_out(baud_out), .cnt(div_cnt), .period(div_period),
        .running(div_running)
    );
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [2:0]       sel,
    input logic             mode,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] period,
    input logic             in_run,
    input logic             out
);
    p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (out == 1'b0));

    p_no_tick_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_run |-> (cnt < period));

    p_period_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        period != '0);

    p_reserved_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && in_run && sel == 3'b111) |=> (cnt == $past(cnt)));

    p_pulse_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(sel) && mode && out && sel != 3'b000) |=> (!out || !mode));
endmodule

bind baud_clkgen bcg_chk #(.CNT_W(PRESET_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .run(run_q), .sel(src_sel), .mode(pulse_mode),
    .tick(src_tick), .cnt(div_cnt), .period(div_period), .in_run(div_running),
    .out(baud_out)
);

// File: tb/baud_clkgen_tb_top.sv
module baud_clkgen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_clk = 1'b0;
    logic       ext_en = 1'b0;
    logic       baud_out;

    int checks = 0;
    int errors = 0;
    localparam int EXT_HALF = 3;
    localparam int TMO = 20000;

    always #5 clk = ~clk;

    baud_clkgen dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
        .baud_out(baud_out)
    );

    initial forever begin
        repeat (EXT_HALF) @(negedge clk);
        if (ext_en) ext_clk = ~ext_clk;
    end

    function automatic int tick_div(input int sel);
        case (sel)
            0: return 1;
            1: return 2;
            2: return 16;
            3: return 32;
            4: return 64;
            5: return 128;
            6: return 2 * EXT_HALF;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_period(input int n, input int sel, input bit pulse);
        int ne = (n == 0) ? 1 : n;
        return ne * tick_div(sel) * (pulse ? 1 : 2);
    endfunction

    function automatic int exp_high(input int n, input int sel, input bit pulse);
        int ne = (n == 0) ? 1 : n;
        return pulse ? 1 : ne * tick_div(sel);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic configure(input int n, input int sel, input bit pulse);
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd0, 8'(n >> 8));
        wr_reg(2'd1, 8'(n));
        wr_reg(2'd2, {3'b000, pulse, 1'b1, 3'(sel)});
    endtask

    // cycles (sampled at negedge) until baud_out reaches level lvl from the other level
    task automatic wait_edge(input bit lvl, output int cyc);
        bit prev = baud_out;
        cyc = 0;
        for (int i = 0; i < TMO; i++) begin
            @(negedge clk);
            cyc++;
            if (baud_out == lvl && prev != lvl) return;
            prev = baud_out;
        end
        cyc = -1;
    endtask

    task automatic measure(input int n, input int sel, input bit pulse, input string req);
        int c, per, hi;
        wait_edge(1'b1, c);
        wait_edge(1'b0, hi);
        wait_edge(1'b1, c);
        per = (hi < 0 || c < 0) ? -1 : hi + c;
        check(per == exp_period(n, sel, pulse), {req, " period"}, per, exp_period(n, sel, pulse));
        check(hi == exp_high(n, sel, pulse), {req, " high"}, hi, exp_high(n, sel, pulse));
    endtask

    initial begin
        int c, n, sel;
        bit pulse;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check(baud_out == 1'b0, "R6 reset out", baud_out, 0);
        bus_addr = 2'd2; #1;
        check(bus_rdata == 8'h00, "R2 reset ctrl", bus_rdata, 0);

        // R1 / R2: split preset, write-only bytes, control readback
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'h05);
        wr_reg(2'd2, 8'hF2);
        bus_addr = 2'd0; #1;
        check(bus_rdata == 8'h00, "R2 hi read", bus_rdata, 0);
        bus_addr = 2'd1; #1;
        check(bus_rdata == 8'h00, "R2 lo read", bus_rdata, 0);
        bus_addr = 2'd2; #1;
        check(bus_rdata == 8'h12, "R2 ctrl read", bus_rdata, 8'h12);

        // R1: high byte matters, low byte kept by a high write
        configure(300, 0, 1'b0);
        measure(300, 0, 1'b0, "R1 R3 hi byte");
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd2, 8'h08);
        measure(44, 0, 1'b0, "R1 low byte kept");

        // R7: zero preset
        configure(0, 0, 1'b0);
        measure(0, 0, 1'b0, "R7 zero square");
        configure(0, 1, 1'b1);
        measure(0, 1, 1'b1, "R7 zero pulse");

        // R5 slowest prescale, R4 pulse
        configure(2, 5, 1'b1);
        measure(2, 5, 1'b1, "R5 R4 div128");

        // R10: external source
        ext_en = 1'b1;
        configure(3, 6, 1'b0);
        measure(3, 6, 1'b0, "R10 ext square");
        configure(4, 6, 1'b1);
        measure(4, 6, 1'b1, "R10 ext pulse");
        ext_en = 1'b0;

        // R9: preset change mid-period
        configure(40, 0, 1'b0);
        wait_edge(1'b1, c);
        wait_edge(1'b1, c);
        repeat (5) @(negedge clk);
        wr_reg(2'd1, 8'd10);
        wait_edge(1'b0, c);
        check(c == 40 - 7, "R9 old half kept", c, 33);
        wait_edge(1'b1, c);
        check(c == 10, "R9 new half", c, 10);

        // R8: reserved source freezes output
        configure(1, 7, 1'b0);
        begin
            int edges = 0;
            bit prev = baud_out;
            for (int i = 0; i < 600; i++) begin
                @(negedge clk);
                if (baud_out != prev) edges++;
                prev = baud_out;
            end
            check(edges == 0, "R8 frozen", edges, 0);
        end

        // R6: stop holds output low
        configure(3, 0, 1'b0);
        wait_edge(1'b1, c);
        wr_reg(2'd2, 8'h00);
        begin
            int highs = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (baud_out) highs++;
            end
            check(highs == 0, "R6 held low", highs, 0);
        end

        // random configurations
        for (int k = 0; k < 12; k++) begin
            n = $urandom_range(0, 20);
            sel = $urandom_range(0, 5);
            pulse = 1'($urandom_range(0, 1));
            if (pulse && exp_period(n, sel, pulse) < 2) n = 2;
            configure(n, sel, pulse);
            measure(n, sel, pulse, pulse ? "R4 R5 random" : "R3 R5 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule